// File: doc/BRIEF.md
# Nested Page Table Walker

This block translates a guest-physical address into a host-physical address. It walks a second-level page table that sits in ordinary memory, reached through a single read/write memory port. A root pointer input selects the walk depth (four or five levels), whether accessed/dirty flags are maintained, and the frame of the top-level table. Each request carries a 52-bit guest-physical address and an access kind (read, write or instruction fetch). Two further request bits mark a user-mode fetch and an access to the guest's own paging structures.

At each level the walker fetches one 64-bit entry. It classifies the entry as not present, misconfigured, lacking permission, or usable. When flag maintenance is on, it sets the accessed bit in the entry and, at the leaf, the dirty bit. The entry is written back only when a flag actually changes. The walk ends at a level-1 entry, or early at a large-page leaf on level 3 or level 2. The walker answers with a one-cycle response that carries a fault class and, on success, the host-physical address. Misconfiguration and violation are reported as separate fault codes.

Top module: `nptw_walker`

## Requirements
- R1: Root pointer bits 5:3 select the depth: 3 gives a 4-level walk and 4 gives a 5-level walk. Any other value ends the request with a misconfiguration fault and makes no memory access. Root bits PA_W-1:12 hold the top table frame.
- R2: The entry for level L is read at address {table frame, GPA[12+9*(L-1)+8 : 12+9*(L-1)], 3'b000}. A non-leaf entry's bits PA_W-1:12 give the frame of the next table. A 4-level walk with no faults and no flag updates makes exactly four reads.
- R3: The access kind is coded 0 = read, 1 = write, 2 = fetch. Every entry used must grant it: entry bit 0 for a read, bit 1 for a write, bit 2 for a supervisor fetch, or bit 10 for a user fetch. Otherwise the walk ends with a violation.
- R4: An entry whose bits 2:0 are all zero is not present and ends the walk with a violation.
- R5: An entry that has bit 1 set with bit 0 clear, or any bit set in 51:PA_W, or bit 7 set at level 4 or 5, ends the walk with a misconfiguration. Fault codes are 0 = none, 1 = violation, 2 = misconfiguration.
- R6: A level-1 entry is always a leaf, and so is a level-3 or level-2 entry with bit 7 set. The output address takes the leaf frame bits above 12+9*(L-1) and the guest address bits below that point.
- R7: With root bit 6 set, the walk sets bit 8 (accessed) in every entry it uses. It sets bit 9 (dirty) only in the leaf, and only for a write or for a request flagged as a paging-structure access.
- R8: With root bit 6 clear, no entry is written. The entry that ends a walk with a fault is never written.
- R9: An entry is written back, to the address it was read from, only when a flag changes from 0 to 1. The walk does not proceed until that write is acknowledged.
- R10: A request is accepted on req_valid while busy is low. The result appears as a one-cycle resp_valid pulse, and resp_hpa is zero whenever resp_fault is non-zero.
- R11: Once raised, mem_req stays high with stable address, direction and write data until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_ptr | input | 64 | Root pointer: depth, flag enable, top table frame |
| req_valid | input | 1 | Start a translation (taken when busy is low) |
| req_gpa | input | GPA_W | Guest-physical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Fetch is a user-mode fetch |
| req_pgtbl | input | 1 | Access targets guest paging structures |
| busy | output | 1 | Walk in progress |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 2 | Fault class: 0 none, 1 violation, 2 misconfiguration |
| resp_hpa | output | PA_W | Translated host-physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | PA_W | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_rdata | input | 64 | Entry value read, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
On every cycle the assertions check the memory handshake hold (R11), the single-cycle response and zero address on faults (R10), and silence on the memory port when idle. They also check that write-backs happen only with flags enabled, always set the accessed bit, and target the slot just read (R7, R8, R9). Translation results, walk depth, large-page address merging, the fault classification, and exactly which entries gain accessed or dirty flags can only be shown by the bench's scenarios. Those scenarios build tables in a memory model and compare responses and memory contents against hand-derived values.

// File: rtl/nptw_pkg.sv
package nptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_VIOL   = 2'd1,
    FLT_MISCFG = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE,
    ST_DONE
  } wstate_e;

  localparam int unsigned ENTRY_W  = 64;
  localparam int unsigned IDX_W    = 9;
  localparam int unsigned PG_SHIFT = 12;
endpackage

// File: rtl/nptw_slot_addr.sv
module nptw_slot_addr #(
  parameter int unsigned GPA_W = 52,
  parameter int unsigned PA_W  = 48
) (
  input  logic [PA_W-13:0]  table_frame,
  input  logic [GPA_W-1:0]  gpa,
  input  logic [2:0]        level,
  output logic [PA_W-1:0]   slot_addr
);
  import nptw_pkg::*;

  logic [63:0]      gpa_x;
  logic [IDX_W-1:0] idx;
  int unsigned      shamt;

  always_comb begin
    gpa_x     = 64'(gpa);
    shamt     = PG_SHIFT + IDX_W * (32'(level) - 1);
    idx       = IDX_W'(gpa_x >> shamt);
    slot_addr = {table_frame, idx, 3'b000};
  end
endmodule

// File: rtl/nptw_entry_eval.sv
module nptw_entry_eval #(
  parameter int unsigned PA_W = 48
) (
  input  logic [63:0] entry,
  input  logic [2:0]  level,
  input  logic [1:0]  kind,
  input  logic        user,
  input  logic        dirty_req,
  input  logic        ad_en,
  output logic        not_present,
  output logic        misconfig,
  output logic        perm_ok,
  output logic        is_leaf,
  output logic [63:0] upd_entry,
  output logic        upd_needed
);
  import nptw_pkg::*;

  logic rsv_set;

  generate
    if (PA_W < 52) begin : g_rsv
      assign rsv_set = |entry[51:PA_W];
    end else begin : g_norsv
      assign rsv_set = 1'b0;
    end
  endgenerate

  always_comb begin
    not_present = (entry[2:0] == 3'b000);
    misconfig   = (entry[1] & ~entry[0]) | rsv_set | (entry[7] & (level >= 3'd4));
    is_leaf     = (level == 3'd1) | (entry[7] & ((level == 3'd2) | (level == 3'd3)));
    case (kind)
      ACC_READ:  perm_ok = entry[0];
      ACC_WRITE: perm_ok = entry[1];
      ACC_FETCH: perm_ok = user ? entry[10] : entry[2];
      default:   perm_ok = 1'b0;
    endcase
    upd_entry    = entry;
    upd_entry[8] = entry[8] | ad_en;
    upd_entry[9] = entry[9] | (ad_en & is_leaf & dirty_req);
    upd_needed   = (upd_entry != entry);
  end
endmodule

// File: rtl/nptw_leaf_addr.sv
module nptw_leaf_addr #(
  parameter int unsigned GPA_W = 52,
  parameter int unsigned PA_W  = 48
) (
  input  logic [63:0]      entry,
  input  logic [GPA_W-1:0] gpa,
  input  logic [2:0]       level,
  output logic [PA_W-1:0]  hpa
);
  import nptw_pkg::*;

  logic [63:0] gpa_x;
  logic [63:0] mask;
  logic [63:0] frame_x;
  logic [63:0] merged;

  always_comb begin
    gpa_x   = 64'(gpa);
    mask    = (64'd1 << (PG_SHIFT + IDX_W * (32'(level) - 1))) - 64'd1;
    frame_x = 64'({entry[PA_W-1:PG_SHIFT], 12'h000});
    merged  = (frame_x & ~mask) | (gpa_x & mask);
    hpa     = merged[PA_W-1:0];
  end
endmodule

// File: rtl/nptw_walker.sv
module nptw_walker #(
  parameter int unsigned GPA_W = 52,
  parameter int unsigned PA_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       root_ptr,
  input  logic              req_valid,
  input  logic [GPA_W-1:0]  req_gpa,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              req_pgtbl,
  output logic              busy,
  output logic              resp_valid,
  output logic [1:0]        resp_fault,
  output logic [PA_W-1:0]   resp_hpa,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack
);
  import nptw_pkg::*;

  localparam int unsigned FRAME_W = PA_W - PG_SHIFT;

  wstate_e             state_q, state_d;
  logic [GPA_W-1:0]    gpa_q, gpa_d;
  logic [1:0]          kind_q, kind_d;
  logic                user_q, user_d;
  logic                dirty_q, dirty_d;
  logic                ad_q, ad_d;
  logic [2:0]          level_q, level_d;
  logic [FRAME_W-1:0]  frame_q, frame_d;
  logic [63:0]         entry_q, entry_d;
  logic [1:0]          fault_q, fault_d;
  logic [PA_W-1:0]     hpa_q, hpa_d;

  logic [PA_W-1:0]     slot_addr;
  logic                e_np, e_mc, e_ok, e_leaf, e_upd;
  logic [63:0]         e_new;
  logic [PA_W-1:0]     leaf_hpa;

  nptw_slot_addr #(.GPA_W(GPA_W), .PA_W(PA_W)) u_slot (
    .table_frame(frame_q), .gpa(gpa_q), .level(level_q), .slot_addr(slot_addr)
  );

  nptw_entry_eval #(.PA_W(PA_W)) u_eval (
    .entry(entry_q), .level(level_q), .kind(kind_q), .user(user_q),
    .dirty_req(dirty_q), .ad_en(ad_q),
    .not_present(e_np), .misconfig(e_mc), .perm_ok(e_ok), .is_leaf(e_leaf),
    .upd_entry(e_new), .upd_needed(e_upd)
  );

  nptw_leaf_addr #(.GPA_W(GPA_W), .PA_W(PA_W)) u_leaf (
    .entry(entry_q), .gpa(gpa_q), .level(level_q), .hpa(leaf_hpa)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    gpa_d   = gpa_q;
    kind_d  = kind_q;
    user_d  = user_q;
    dirty_d = dirty_q;
    ad_d    = ad_q;
    level_d = level_q;
    frame_d = frame_q;
    entry_d = entry_q;
    fault_d = fault_q;
    hpa_d   = hpa_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          gpa_d   = req_gpa;
          kind_d  = req_kind;
          user_d  = req_user;
          dirty_d = (req_kind == ACC_WRITE) | req_pgtbl;
          ad_d    = root_ptr[6];
          frame_d = root_ptr[PA_W-1:PG_SHIFT];
          hpa_d   = '0;
          fault_d = FLT_NONE;
          if (root_ptr[5:3] == 3'd3) begin
            level_d = 3'd4;
            state_d = ST_READ;
          end else if (root_ptr[5:3] == 3'd4) begin
            level_d = 3'd5;
            state_d = ST_READ;
          end else begin
            fault_d = FLT_MISCFG;
            state_d = ST_DONE;
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          entry_d = mem_rdata;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (e_np) begin
          fault_d = FLT_VIOL;
          state_d = ST_DONE;
        end else if (e_mc) begin
          fault_d = FLT_MISCFG;
          state_d = ST_DONE;
        end else if (!e_ok) begin
          fault_d = FLT_VIOL;
          state_d = ST_DONE;
        end else if (e_upd) begin
          state_d = ST_WRITE;
        end else if (e_leaf) begin
          hpa_d   = leaf_hpa;
          state_d = ST_DONE;
        end else begin
          frame_d = entry_q[PA_W-1:PG_SHIFT];
          level_d = level_q - 3'd1;
          state_d = ST_READ;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (e_leaf) begin
            hpa_d   = leaf_hpa;
            state_d = ST_DONE;
          end else begin
            frame_d = entry_q[PA_W-1:PG_SHIFT];
            level_d = level_q - 3'd1;
            state_d = ST_READ;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gpa_q   <= '0;
      kind_q  <= '0;
      user_q  <= 1'b0;
      dirty_q <= 1'b0;
      ad_q    <= 1'b0;
      level_q <= 3'd1;
      frame_q <= '0;
      entry_q <= '0;
      fault_q <= '0;
      hpa_q   <= '0;
    end else begin
      state_q <= state_d;
      gpa_q   <= gpa_d;
      kind_q  <= kind_d;
      user_q  <= user_d;
      dirty_q <= dirty_d;
      ad_q    <= ad_d;
      level_q <= level_d;
      frame_q <= frame_d;
      entry_q <= entry_d;
      fault_q <= fault_d;
      hpa_q   <= hpa_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign resp_valid = (state_q == ST_DONE);
  assign resp_fault = fault_q;
  assign resp_hpa   = hpa_q;
  assign mem_req    = (state_q == ST_READ) | (state_q == ST_WRITE);
  assign mem_we     = (state_q == ST_WRITE);
  assign mem_addr   = slot_addr;
  assign mem_wdata  = (state_q == ST_WRITE) ? e_new : 64'd0;
endmodule

// File: rtl/nptw_walker_chk.sv
module nptw_walker_chk #(
  parameter int unsigned PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            resp_valid,
  input logic [1:0]      resp_fault,
  input logic [PA_W-1:0] resp_hpa,
  input logic            mem_req,
  input logic            mem_we,
  input logic [PA_W-1:0] mem_addr,
  input logic [63:0]     mem_wdata,
  input logic            mem_ack,
  input logic            ad_en
);
  logic [PA_W-1:0] last_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rd_q <= '0;
    else if (mem_req && !mem_we && mem_ack) last_rd_q <= mem_addr;
  end

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_fault_hpa_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> (resp_hpa == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_we_needs_ad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ad_en);

  p_wb_sets_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);

  p_wb_same_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == last_rd_q));
endmodule

bind nptw_walker nptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .resp_hpa(resp_hpa), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .ad_en(ad_q)
);

// File: tb/nptw_walker_bench.sv
module nptw_walker_bench;
  localparam int unsigned GPA_W = 52;
  localparam int unsigned PA_W  = 48;
  localparam time CLK_PERIOD    = 10ns;

  localparam logic [63:0] G    = 64'h0000_0080_8060_4123;
  localparam logic [63:0] G5   = G | (64'd1 << 48);
  localparam logic [63:0] LEAF = (64'hABC << 12) | 64'h7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       root_ptr = '0;
  logic              req_valid = 1'b0;
  logic [GPA_W-1:0]  req_gpa = '0;
  logic [1:0]        req_kind = '0;
  logic              req_user = 1'b0;
  logic              req_pgtbl = 1'b0;
  logic              busy, resp_valid;
  logic [1:0]        resp_fault;
  logic [PA_W-1:0]   resp_hpa;
  logic              mem_req, mem_we;
  logic [PA_W-1:0]   mem_addr;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata = '0;
  logic              mem_ack = 1'b0;

  bit [63:0] mem [longint];
  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0]      got_fault;
  logic [PA_W-1:0] got_hpa;

  nptw_walker #(.GPA_W(GPA_W), .PA_W(PA_W)) u_nptw_walker (
    .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr), .req_valid(req_valid),
    .req_gpa(req_gpa), .req_kind(req_kind), .req_user(req_user),
    .req_pgtbl(req_pgtbl), .busy(busy), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_hpa(resp_hpa), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model with programmable latency
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        if (mem_we) begin
          mem[longint'(mem_addr >> 3)] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata <= mem.exists(longint'(mem_addr >> 3)) ? mem[longint'(mem_addr >> 3)] : 64'd0;
          rd_cnt++;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic longint key(input longint frame, input longint idx);
    return frame * 512 + idx;
  endfunction

  function automatic logic [63:0] root(input logic [63:0] frame, input bit ad, input logic [2:0] depth);
    return (frame << 12) | (64'(ad) << 6) | (64'(depth) << 3);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic build4();
    mem.delete();
    mem[key(64'h10, 1)] = (64'h11 << 12) | 64'h7;
    mem[key(64'h11, 2)] = (64'h12 << 12) | 64'h7;
    mem[key(64'h12, 3)] = (64'h13 << 12) | 64'h7;
    mem[key(64'h13, 4)] = LEAF;
  endtask

  task automatic walk(input logic [63:0] rp, input logic [63:0] gpa, input logic [1:0] kind,
                      input bit user, input bit pgtbl);
    int guard;
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk);
    root_ptr  = rp;
    req_gpa   = gpa[GPA_W-1:0];
    req_kind  = kind;
    req_user  = user;
    req_pgtbl = pgtbl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!resp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    got_fault = resp_fault;
    got_hpa   = resp_hpa;
    if (!resp_valid) check("R10 response timeout", 0, 1);
    @(negedge clk);
    check("R10 single-cycle resp", 64'(resp_valid), 0);
  endtask

  task automatic t_reset();
    check("R10 reset busy", 64'(busy), 0);
    check("R10 reset resp_valid", 64'(resp_valid), 0);
    check("R11 reset mem_req", 64'(mem_req), 0);
  endtask

  task automatic t_basic4();
    build4();
    walk(root(64'h10, 0, 3'd3), G, 2'd0, 0, 0);
    check("R2 4-level fault", 64'(got_fault), 0);
    check("R2 4-level hpa", 64'(got_hpa), 64'hABC123);
    check("R2 read count", rd_cnt, 4);
    check("R8 no writes with flags off", wr_cnt, 0);
  endtask

  task automatic t_ad_read();
    build4();
    walk(root(64'h10, 1, 3'd3), G, 2'd0, 0, 0);
    check("R7 read hpa", 64'(got_hpa), 64'hABC123);
    check("R7 A on level4", mem[key(64'h10, 1)], (64'h11 << 12) | 64'h107);
    check("R7 A on level3", mem[key(64'h11, 2)], (64'h12 << 12) | 64'h107);
    check("R7 A on level2", mem[key(64'h12, 3)], (64'h13 << 12) | 64'h107);
    check("R7 A only on leaf read", mem[key(64'h13, 4)], LEAF | 64'h100);
    check("R9 four write-backs", wr_cnt, 4);
    walk(root(64'h10, 1, 3'd3), G, 2'd0, 0, 0);
    check("R9 no rewrite when set", wr_cnt, 0);
    walk(root(64'h10, 1, 3'd3), G, 2'd1, 0, 0);
    check("R7 write sets D on leaf", mem[key(64'h13, 4)], LEAF | 64'h300);
    check("R9 single write for D", wr_cnt, 1);
    check("R7 no D on non-leaf", mem[key(64'h12, 3)], (64'h13 << 12) | 64'h107);
  endtask

  task automatic t_pgtbl();
    build4();
    walk(root(64'h10, 1, 3'd3), G, 2'd0, 0, 1);
    check("R7 paging-structure access sets D", mem[key(64'h13, 4)], LEAF | 64'h300);
  endtask

  task automatic t_large();
    build4();
    mem[key(64'h12, 3)] = 64'h4_0000_0000 | 64'h87;
    walk(root(64'h10, 0, 3'd3), G, 2'd0, 0, 0);
    check("R6 2MB fault", 64'(got_fault), 0);
    check("R6 2MB hpa", 64'(got_hpa), 64'h4_0000_4123);
    check("R6 2MB reads", rd_cnt, 3);
    build4();
    mem[key(64'h11, 2)] = 64'h80_0000_0000 | 64'h87;
    walk(root(64'h10, 1, 3'd3), G, 2'd1, 0, 0);
    check("R6 1GB hpa", 64'(got_hpa), 64'h80_0060_4123);
    check("R7 D on 1GB leaf", mem[key(64'h11, 2)], 64'h80_0000_0000 | 64'h387);
  endtask

  task automatic t_faults();
    build4();
    mem[key(64'h13, 4)] = 64'hABC000;
    walk(root(64'h10, 1, 3'd3), G, 2'd0, 0, 0);
    check("R4 not present fault", 64'(got_fault), 1);
    check("R10 hpa zero on fault", 64'(got_hpa), 0);
    check("R8 faulting entry untouched", mem[key(64'h13, 4)], 64'hABC000);

    build4();
    mem[key(64'h13, 4)] = 64'hABC005;
    walk(root(64'h10, 1, 3'd3), G, 2'd1, 0, 0);
    check("R3 write without W", 64'(got_fault), 1);
    check("R8 no flag on denied write", mem[key(64'h13, 4)], 64'hABC005);

    build4();
    walk(root(64'h10, 0, 3'd3), G, 2'd2, 1, 0);
    check("R3 user fetch without bit10", 64'(got_fault), 1);
    mem[key(64'h10, 1)] |= 64'h400;
    mem[key(64'h11, 2)] |= 64'h400;
    mem[key(64'h12, 3)] |= 64'h400;
    mem[key(64'h13, 4)] |= 64'h400;
    walk(root(64'h10, 0, 3'd3), G, 2'd2, 1, 0);
    check("R3 user fetch with bit10", 64'(got_fault), 0);
    build4();
    mem[key(64'h11, 2)] = (64'h12 << 12) | 64'h3;
    walk(root(64'h10, 0, 3'd3), G, 2'd2, 0, 0);
    check("R3 non-leaf lacks X", 64'(got_fault), 1);

    build4();
    mem[key(64'h13, 4)] = 64'hABC002;
    walk(root(64'h10, 0, 3'd3), G, 2'd1, 0, 0);
    check("R5 write-only misconfig", 64'(got_fault), 2);
    build4();
    mem[key(64'h11, 2)] |= (64'd1 << 50);
    walk(root(64'h10, 0, 3'd3), G, 2'd0, 0, 0);
    check("R5 reserved bit misconfig", 64'(got_fault), 2);
    build4();
    mem[key(64'h10, 1)] |= 64'h80;
    walk(root(64'h10, 0, 3'd3), G, 2'd0, 0, 0);
    check("R5 bit7 at level4 misconfig", 64'(got_fault), 2);
  endtask

  task automatic t_depth();
    build4();
    walk(root(64'h10, 0, 3'd5), G, 2'd0, 0, 0);
    check("R1 bad depth misconfig", 64'(got_fault), 2);
    check("R1 bad depth no access", rd_cnt + wr_cnt, 0);
    mem[key(64'h20, 1)] = (64'h10 << 12) | 64'h7;
    walk(root(64'h20, 0, 3'd4), G5, 2'd0, 0, 0);
    check("R1 5-level hpa", 64'(got_hpa), 64'hABC123);
    check("R1 5-level reads", rd_cnt, 5);
  endtask

  task automatic t_slow();
    build4();
    lat = 3;
    walk(root(64'h10, 1, 3'd3), G, 2'd1, 0, 0);
    check("R11 slow memory hpa", 64'(got_hpa), 64'hABC123);
    check("R9 slow memory leaf flags", mem[key(64'h13, 4)], LEAF | 64'h300);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic4();
    t_ad_read();
    t_pgtbl();
    t_large();
    t_faults();
    t_depth();
    t_slow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule